// File: doc/BRIEF.md
# Interrupt-Acknowledge Bus Adapter

This block is glue logic between a CPU with separate I/O and memory cycles and a serial communications peripheral whose interrupt sources form a priority daisy chain. The CPU answers an interrupt with two acknowledge pulses and no read strobe. The adapter turns the first pulse into the peripheral's acknowledge level. After the chain has had time to settle, it turns the second pulse into a gated read strobe, so that the peripheral drives its vector onto the data bus. It holds the CPU ready line low for as long as the vector read needs.

Ordinary I/O reads reach the peripheral one clock after the CPU strobe. For writes, the adapter delays the leading edge of the peripheral strobe so that data setup is met, and adds a wait state so that the strobe is wide enough. All timings are parameters in CPU clock cycles. The defaults suit a 125 ns CPU clock: 7 settle cycles, 2 vector-read waits, 1 write-edge delay cycle and 1 write wait. Every input and output is active high.

Top module: `iack_bus_adapter`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `per_iack`, `per_rd` and `per_wr` are 0 and `cpu_ready` is 1. This holds even if reset arrives in the middle of a write.
- R2: The first clock edge that samples `cpu_ack` high while the adapter is idle raises `per_iack`. `per_iack` stays high through the gap between the two pulses, and `cpu_ready` stays 1 during the first pulse and the gap.
- R3: `per_rd` is driven during the second acknowledge pulse without any CPU read strobe and without `cpu_io_sel` or `cs_match`. It rises no earlier than SETTLE_CYC+1 edges after `per_iack` rose, where SETTLE_CYC is SETTLE_NS divided by CLK_PERIOD_NS, rounded up (7 by default). If the gap already covered the settle time, `per_rd` rises on the second edge of the second pulse.
- R4: From the first edge of the second pulse, `cpu_ready` is 0 until settling ends, and then for ACK_WAITS further edges while `per_rd` is high (2 by default). After that, `cpu_ready` returns to 1 while the pulse lasts.
- R5: The first edge that samples `cpu_ack` low after the second pulse drops both `per_iack` and `per_rd` together.
- R6: An I/O read is a cycle with `cpu_io_sel`=1, `cs_match`=1 and `cpu_rd`=1. It raises `per_rd` at the next edge with no wait state, and `per_rd` falls at the edge that samples `cpu_rd` low.
- R7: For an I/O write (`cpu_io_sel`=1, `cs_match`=1, `cpu_wr`=1), `per_wr` rises WR_DELAY_CYC edges later than a read strobe would: on the second edge by default. `per_wr` falls at the edge that samples `cpu_wr` low.
- R8: During an I/O write, `cpu_ready` is 0 for the delay cycles and then for the first WR_WAITS edges of `per_wr` (2 low cycles in total by default). It then returns to 1.
- R9: A memory cycle (`cpu_io_sel`=0), or a cycle with `cs_match`=0, raises neither `per_rd` nor `per_wr` and leaves `cpu_ready` at 1.
- R10: `per_rd` and `per_wr` are never high together. A cycle with `cpu_rd` and `cpu_wr` both high drives neither of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_io_sel | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_ack | input | 1 | CPU interrupt-acknowledge strobe |
| cs_match | input | 1 | Address decode hit for the peripheral |
| per_iack | output | 1 | Interrupt acknowledge to the peripheral |
| per_rd | output | 1 | Read strobe to the peripheral |
| per_wr | output | 1 | Write strobe to the peripheral |
| cpu_ready | output | 1 | Ready to the CPU; 0 inserts a wait state |

## Verification
Every output is decoded from registers, so each result becomes visible one edge after the input change that causes it. The exceptions are the write strobe, which comes WR_DELAY_CYC edges later, and the vector read, which comes only after the settle count. The bench changes inputs 2 ns after a rising edge, steps one edge at a time, and compares outputs 2 ns after each following edge. It checks every cycle of the acknowledge and write sequences, so an early or late strobe or ready change is caught in the exact cycle where it goes wrong.

// File: rtl/iack_adapter_pkg.sv
package iack_adapter_pkg;

    typedef enum logic [2:0] {
        ACK_IDLE,
        ACK_FIRST,
        ACK_GAP,
        ACK_SETTLE,
        ACK_VECTOR
    } ack_state_e;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_DELAY,
        WR_DRIVE
    } wr_state_e;

    typedef struct packed {
        logic io;
        logic cs;
        logic rd;
        logic wr;
        logic ack;
    } cpu_req_t;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/iack_seq.sv
module iack_seq
    import iack_adapter_pkg::*;
#(
    parameter int SETTLE_CYC = 7,
    parameter int ACK_WAITS  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ack_in,
    input  logic start_ok,
    output logic iack,
    output logic vec_rd,
    output logic hold,
    output logic idle
);
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam int AW = $clog2(ACK_WAITS + 1);
    localparam logic [SW-1:0] SETTLE_V = SW'(SETTLE_CYC);
    localparam logic [AW-1:0] WAITS_V  = AW'(ACK_WAITS);

    ack_state_e    st_q, st_d;
    logic [SW-1:0] settle_q;
    logic [AW-1:0] wait_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ACK_IDLE:   if (ack_in && start_ok) st_d = ACK_FIRST;
            ACK_FIRST:  if (!ack_in) st_d = ACK_GAP;
            ACK_GAP:    if (ack_in) st_d = ACK_SETTLE;
            ACK_SETTLE: if (settle_q >= SETTLE_V) st_d = ACK_VECTOR;
            ACK_VECTOR: if (!ack_in) st_d = ACK_IDLE;
            default:    st_d = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ACK_IDLE;
            settle_q <= '0;
            wait_q   <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ACK_IDLE)
                settle_q <= '0;
            else if (settle_q < SETTLE_V)
                settle_q <= settle_q + 1'b1;
            if (st_q != ACK_VECTOR)
                wait_q <= '0;
            else if (wait_q < WAITS_V)
                wait_q <= wait_q + 1'b1;
        end
    end

    assign idle   = (st_q == ACK_IDLE);
    assign iack   = !idle;
    assign vec_rd = (st_q == ACK_VECTOR);
    assign hold   = (st_q == ACK_SETTLE) || (vec_rd && (wait_q < WAITS_V));

endmodule

// File: rtl/wr_seq.sv
module wr_seq
    import iack_adapter_pkg::*;
#(
    parameter int DELAY_CYC = 1,
    parameter int WAITS     = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic wr_in,
    output logic strobe,
    output logic hold,
    output logic idle
);
    localparam int DW = $clog2(DELAY_CYC + 1);
    localparam int WW = $clog2(WAITS + 1);
    localparam logic [DW-1:0] DLY_LAST = DW'(DELAY_CYC - 1);
    localparam logic [WW-1:0] WAITS_V  = WW'(WAITS);

    wr_state_e     st_q, st_d;
    logic [DW-1:0] dly_q;
    logic [WW-1:0] wait_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WR_IDLE:  if (go) st_d = WR_DELAY;
            WR_DELAY: if (!wr_in) st_d = WR_IDLE;
                      else if (dly_q == DLY_LAST) st_d = WR_DRIVE;
            WR_DRIVE: if (!wr_in) st_d = WR_IDLE;
            default:  st_d = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= WR_IDLE;
            dly_q  <= '0;
            wait_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q != WR_DELAY)
                dly_q <= '0;
            else
                dly_q <= dly_q + 1'b1;
            if (st_q != WR_DRIVE)
                wait_q <= '0;
            else if (wait_q < WAITS_V)
                wait_q <= wait_q + 1'b1;
        end
    end

    assign idle   = (st_q == WR_IDLE);
    assign strobe = (st_q == WR_DRIVE);
    assign hold   = (st_q == WR_DELAY) || (strobe && (wait_q < WAITS_V));

endmodule

// File: rtl/rd_gate.sv
module rd_gate (
    input  logic clk,
    input  logic rst,
    input  logic qualify,
    output logic strobe
);
    always_ff @(posedge clk) begin
        if (rst) strobe <= 1'b0;
        else     strobe <= qualify;
    end
endmodule

// File: rtl/iack_bus_adapter.sv
module iack_bus_adapter
    import iack_adapter_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 125,
    parameter int SETTLE_NS     = 800,
    parameter int ACK_WAITS     = 2,
    parameter int WR_DELAY_CYC  = 1,
    parameter int WR_WAITS      = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic cpu_io_sel,
    input  logic cpu_rd,
    input  logic cpu_wr,
    input  logic cpu_ack,
    input  logic cs_match,
    output logic per_iack,
    output logic per_rd,
    output logic per_wr,
    output logic cpu_ready
);
    localparam int SETTLE_CYC = ceil_div(SETTLE_NS, CLK_PERIOD_NS);

    cpu_req_t req;
    logic ack_idle, wr_idle, io_rd_q, vec_rd, ack_hold, wr_hold, wr_strobe;
    logic io_hit, bus_quiet;

    assign req       = '{io: cpu_io_sel, cs: cs_match, rd: cpu_rd, wr: cpu_wr, ack: cpu_ack};
    assign io_hit    = req.io && req.cs;
    assign bus_quiet = ack_idle && !req.ack;

    iack_seq #(
        .SETTLE_CYC (SETTLE_CYC),
        .ACK_WAITS  (ACK_WAITS)
    ) ack_i (
        .clk      (clk),
        .rst      (rst),
        .ack_in   (req.ack),
        .start_ok (wr_idle && !io_rd_q),
        .iack     (per_iack),
        .vec_rd   (vec_rd),
        .hold     (ack_hold),
        .idle     (ack_idle)
    );

    wr_seq #(
        .DELAY_CYC (WR_DELAY_CYC),
        .WAITS     (WR_WAITS)
    ) wr_i (
        .clk    (clk),
        .rst    (rst),
        .go     (io_hit && req.wr && !req.rd && bus_quiet && !io_rd_q),
        .wr_in  (req.wr),
        .strobe (wr_strobe),
        .hold   (wr_hold),
        .idle   (wr_idle)
    );

    rd_gate rd_i (
        .clk     (clk),
        .rst     (rst),
        .qualify (io_hit && req.rd && !req.wr && bus_quiet && wr_idle),
        .strobe  (io_rd_q)
    );

    assign per_rd    = io_rd_q || vec_rd;
    assign per_wr    = wr_strobe;
    assign cpu_ready = !(ack_hold || wr_hold);

endmodule

// File: rtl/iack_bus_adapter_chk.sv
module iack_bus_adapter_chk (
    input logic clk,
    input logic rst,
    input logic cpu_io_sel,
    input logic cpu_rd,
    input logic cpu_wr,
    input logic cpu_ack,
    input logic cs_match,
    input logic per_iack,
    input logic per_rd,
    input logic per_wr,
    input logic cpu_ready
);
    a_r10_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
        !(per_rd && per_wr));

    a_r2_iack_on_pulse: assert property (@(posedge clk) disable iff (rst)
        $rose(per_iack) |-> $past(cpu_ack));

    a_r5_iack_drop: assert property (@(posedge clk) disable iff (rst)
        $fell(per_iack) |-> $past(!cpu_ack));

    a_r9_rd_io_only: assert property (@(posedge clk) disable iff (rst)
        ($rose(per_rd) && !per_iack) |-> $past(cpu_io_sel && cs_match && cpu_rd));

    a_r7_wr_delayed: assert property (@(posedge clk) disable iff (rst)
        $rose(per_wr) |-> $past(!cpu_ready && cpu_wr && !per_wr));

    a_r4_vec_waits: assert property (@(posedge clk) disable iff (rst)
        ($rose(per_rd) && per_iack) |-> (!cpu_ready && $past(!cpu_ready)));
endmodule

bind iack_bus_adapter iack_bus_adapter_chk chk_i (.*);

// File: tb/iack_bus_adapter_tb_top.sv
module iack_bus_adapter_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpu_io_sel = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0, cpu_ack = 1'b0, cs_match = 1'b0;
    logic per_iack, per_rd, per_wr, cpu_ready;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    iack_bus_adapter dut_i (
        .clk        (clk),
        .rst        (rst),
        .cpu_io_sel (cpu_io_sel),
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .cpu_ack    (cpu_ack),
        .cs_match   (cs_match),
        .per_iack   (per_iack),
        .per_rd     (per_rd),
        .per_wr     (per_wr),
        .cpu_ready  (cpu_ready)
    );

    // row: {io, cs, rd, wr, exp_rd, exp_wr, exp_ready, req[3:0]}
    localparam logic [10:0] TBL [0:12] = '{
        {4'b1110, 3'b101, 4'd6},   // R6 read passes
        {4'b1100, 3'b001, 4'd6},   // R6 read ends
        {4'b0110, 3'b001, 4'd9},   // R9 memory read
        {4'b1010, 3'b001, 4'd9},   // R9 no chip select
        {4'b1111, 3'b001, 4'd10},  // R10 both strobes
        {4'b0000, 3'b001, 4'd10},
        {4'b1101, 3'b000, 4'd8},   // R8 delay cycle
        {4'b1101, 3'b010, 4'd7},   // R7 delayed edge
        {4'b1101, 3'b011, 4'd8},   // R8 wait done
        {4'b1101, 3'b011, 4'd7},
        {4'b1100, 3'b001, 4'd7},   // R7 strobe ends
        {4'b0101, 3'b001, 4'd9},   // R9 memory write
        {4'b0000, 3'b001, 4'd9}
    };

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic ei, input logic er,
                             input logic ew, input logic ey);
        check(req, "per_iack", per_iack, ei);
        check(req, "per_rd", per_rd, er);
        check(req, "per_wr", per_wr, ew);
        check(req, "cpu_ready", cpu_ready, ey);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        tick();
        tick();
        check_all("R1", 1'b0, 1'b0, 1'b0, 1'b1);
        rst = 1'b0;
        tick();
        check_all("R1", 1'b0, 1'b0, 1'b0, 1'b1);

        for (int i = 0; i < 13; i++) begin
            {cpu_io_sel, cs_match, cpu_rd, cpu_wr} = TBL[i][10:7];
            tick();
            check_all($sformatf("R%0d row%0d", TBL[i][3:0], i),
                      1'b0, TBL[i][6], TBL[i][5], TBL[i][4]);
        end

        // R2 first pulse, short gap
        cpu_ack = 1'b1;
        tick();                                     // E0
        check_all("R2", 1'b1, 1'b0, 1'b0, 1'b1);
        tick();                                     // E1
        cpu_ack = 1'b0;
        tick();                                     // E2
        check_all("R2", 1'b1, 1'b0, 1'b0, 1'b1);
        tick();                                     // E3
        cpu_ack = 1'b1;
        for (int e = 4; e <= 7; e++) begin
            tick();
            check_all("R3", 1'b1, 1'b0, 1'b0, 1'b0); // R4 settling holds ready low
        end
        tick();                                     // E8 = SETTLE_CYC+1
        check_all("R3", 1'b1, 1'b1, 1'b0, 1'b0);
        tick();                                     // E9
        check_all("R4", 1'b1, 1'b1, 1'b0, 1'b0);
        tick();                                     // E10
        check_all("R4", 1'b1, 1'b1, 1'b0, 1'b1);
        cpu_ack = 1'b0;
        tick();
        check_all("R5", 1'b0, 1'b0, 1'b0, 1'b1);

        // R3 long gap: settle already met
        cpu_ack = 1'b1;
        tick();
        cpu_ack = 1'b0;
        repeat (10) tick();
        check_all("R2", 1'b1, 1'b0, 1'b0, 1'b1);
        cpu_ack = 1'b1;
        tick();
        check_all("R4", 1'b1, 1'b0, 1'b0, 1'b0);
        tick();
        check_all("R3", 1'b1, 1'b1, 1'b0, 1'b0);
        tick();
        check_all("R4", 1'b1, 1'b1, 1'b0, 1'b0);
        tick();
        check_all("R4", 1'b1, 1'b1, 1'b0, 1'b1);
        cpu_ack = 1'b0;
        tick();
        check_all("R5", 1'b0, 1'b0, 1'b0, 1'b1);

        // R1 reset in the middle of a write
        {cpu_io_sel, cs_match, cpu_wr} = 3'b111;
        tick();
        tick();
        check_all("R7", 1'b0, 1'b0, 1'b1, 1'b0);
        rst = 1'b1;
        tick();
        check_all("R1", 1'b0, 1'b0, 1'b0, 1'b1);
        {cpu_io_sel, cs_match, cpu_wr} = 3'b000;
        rst = 1'b0;
        tick();
        check_all("R1", 1'b0, 1'b0, 1'b0, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule